// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Lookup

The block translates a 32-bit virtual address through four translation ways, for an instruction fetch or for a data load or store. Each way picks one entry with the address bits just above its page offset. It compares that entry's page tag and address-space tag, and it turns the tag into a privilege ring through a register of four ring tags. A single matching entry gives the physical address, the page size, a cache mode and the access rights. Anything else yields a fault code.

Ways 0 and 1 map 4 KB pages, way 2 maps 1 MB pages, and way 3 maps 512 MB regions with eight entries. After reset, way 3 holds an identity map of the whole address space and every other entry is empty. An entry write port and a ring-tag write port load translations and address-space tags. A request taken in one cycle is answered in the next.

Top module: `tlb_lookup`

## Requirements
- R1: Each cycle with `req_valid` high gives exactly one response with `rsp_valid` high on the next cycle. No response appears in any other cycle.
- R2: Way w selects entry `vaddr[S+B-1:S]`, with S = 12, 12, 20, 29 and B = 2, 2, 2, 3 for w = 0..3. The entry is a candidate when its stored page tag equals the virtual address with the low S bits cleared and its address-space tag is nonzero.
- R3: The ring register resets to 0x04030201. A candidate's ring is the lowest byte index i with byte i equal to its address-space tag. A tag found in no byte does not match.
- R4: When no way matches, `rsp_cause` is 1 for a fetch and 9 for a load or store.
- R5: When more than one way matches, `rsp_cause` is 2 for a fetch and 10 for a load or store. This check takes priority over R6 and R8.
- R6: For a single match whose ring is numerically below `req_priv`, `rsp_cause` is 3 for a fetch and 11 for a load or store. This check takes priority over R8.
- R7: Attribute decoding works as follows. Values 0 to 11 grant read, with execute from bit 0 and write from bit 1, and take cache mode `attr[3:2]` (0 bypass, 1 write-back, 2 write-through). Value 13 grants read and write with cache mode 3 (isolate). All other values grant nothing, with mode 0. A fetch keeps only execute, and a load or store keeps only read and write.
- R8: A fetch needs execute, a load needs read and a store needs write. A missing right gives cause 4 (fetch), 12 (load) or 13 (store).
- R9: With no fault, `rsp_cause` is 0, `rsp_paddr` is the entry's physical page ORed with the low S address bits, `rsp_page_size` is 2^S and `rsp_cache` is the decoded mode. On a fault, paddr, size and cache read 0.
- R10: Reset clears every address-space tag. The exception is way 3, where entry e maps region e<<29 to itself with tag 1 and attribute 3.
- R11: An entry write stores page tag and physical page with the low S bits cleared, using the low B bits of `wr_idx`. Entry and ring writes are seen by lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_fetch | input | 1 | 1: instruction fetch, 0: data access |
| req_store | input | 1 | Data access is a store (ignored for fetch) |
| req_priv | input | 2 | Current privilege level |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 2 | Way written |
| wr_idx | input | 3 | Entry written |
| wr_vpn | input | 32 | Page tag written |
| wr_ppn | input | 32 | Physical page written |
| wr_asid | input | 8 | Address-space tag written |
| wr_attr | input | 4 | Attribute written |
| ring_wr_en | input | 1 | Ring register write strobe |
| ring_wr_data | input | 32 | Four ring tags, byte i for ring i |
| rsp_valid | output | 1 | Response valid |
| rsp_cause | output | 4 | 0 or fault code |
| rsp_paddr | output | 32 | Physical address |
| rsp_page_size | output | 32 | Page size in bytes |
| rsp_cache | output | 2 | Cache mode |

## Verification
The bench builds the block with its default configuration of four ways and page shifts of 12, 12, 20 and 29. This puts same-address hits in a small way and the large region way within reach, which gives the multi-hit case, and page masks of three different sizes. Removing the reset identity mapping of one region exposes misses. Rewriting the ring register reaches both an unknown address-space tag and a tag that appears in several ring bytes.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
  parameter int unsigned NWAYS   = 4;
  parameter int unsigned MAX_ENT = 8;
  parameter int unsigned VAR_WAY = 3;
  parameter logic [31:0] RING_RESET = 32'h0403_0201;
  localparam int unsigned IDX_W = $clog2(MAX_ENT);
  localparam int unsigned WAY_W = $clog2(NWAYS);

  typedef struct packed {
    logic [31:0] vpn;
    logic [31:0] ppn;
    logic [7:0]  asid;
    logic [3:0]  attr;
  } entry_t;

  typedef enum logic [3:0] {
    C_OK       = 4'd0,
    C_I_MISS   = 4'd1,
    C_I_MULTI  = 4'd2,
    C_I_PRIV   = 4'd3,
    C_F_PROHIB = 4'd4,
    C_D_MISS   = 4'd9,
    C_D_MULTI  = 4'd10,
    C_D_PRIV   = 4'd11,
    C_L_PROHIB = 4'd12,
    C_S_PROHIB = 4'd13
  } cause_e;

  function automatic int unsigned way_shift(int unsigned w);
    case (w)
      0, 1:    return 12;
      2:       return 20;
      default: return 29;
    endcase
  endfunction

  function automatic int unsigned way_ibits(int unsigned w);
    return (w == VAR_WAY) ? 3 : 2;
  endfunction

  function automatic entry_t reset_entry(int unsigned w, int unsigned e);
    entry_t r;
    r = '0;
    if (w == VAR_WAY) begin
      r.vpn  = 32'(e) << 29;
      r.ppn  = 32'(e) << 29;
      r.asid = 8'd1;
      r.attr = 4'd3;
    end
    return r;
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_lookup_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [WAY_W-1:0]       wr_way,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [31:0]            wr_vpn,
  input  logic [31:0]            wr_ppn,
  input  logic [7:0]             wr_asid,
  input  logic [3:0]             wr_attr,
  input  logic [31:0]            lk_vaddr,
  output entry_t                 sel_o   [NWAYS],
  output logic [NWAYS-1:0]       tag_hit_o,
  output logic [31:0]            paddr_o [NWAYS],
  output logic [31:0]            size_o  [NWAYS]
);
  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    localparam int unsigned SH = way_shift(w);
    localparam int unsigned IB = way_ibits(w);
    localparam logic [31:0] LOW  = (32'd1 << SH) - 32'd1;
    localparam logic [31:0] MASK = ~LOW;
    localparam logic [IDX_W-1:0] SLOT_MASK = IDX_W'((1 << IB) - 1);

    entry_t row_q [MAX_ENT];
    entry_t row_d [MAX_ENT];
    logic             wr_hit;
    logic [IDX_W-1:0] wr_slot;
    logic [IB-1:0]    lk_idx;

    assign wr_hit  = wr_en && (wr_way == WAY_W'(w));
    assign wr_slot = wr_idx & SLOT_MASK;

    always_comb begin
      row_d = row_q;
      if (wr_hit) begin
        row_d[wr_slot].vpn  = wr_vpn & MASK;
        row_d[wr_slot].ppn  = wr_ppn & MASK;
        row_d[wr_slot].asid = wr_asid;
        row_d[wr_slot].attr = wr_attr;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < MAX_ENT; e++) row_q[e] <= reset_entry(w, e);
      end else if (wr_hit) begin
        row_q <= row_d;
      end
    end

    assign lk_idx       = lk_vaddr[SH +: IB];
    assign sel_o[w]     = row_q[IDX_W'(lk_idx)];
    assign tag_hit_o[w] = (sel_o[w].asid != 8'd0) && (sel_o[w].vpn == (lk_vaddr & MASK));
    assign paddr_o[w]   = sel_o[w].ppn | (lk_vaddr & LOW);
    assign size_o[w]    = LOW + 32'd1;
  end
endmodule

// File: rtl/tlb_ring_map.sv
module tlb_ring_map
  import tlb_lookup_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic [7:0]       asid_i  [NWAYS],
  output logic [NWAYS-1:0] found_o,
  output logic [1:0]       ring_o  [NWAYS]
);
  logic [31:0] ring_q, ring_d;

  always_comb ring_d = wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ring_q <= RING_RESET;
    else if (wr_en) ring_q <= ring_d;
  end

  for (genvar w = 0; w < NWAYS; w++) begin : g_map
    always_comb begin
      found_o[w] = 1'b0;
      ring_o[w]  = 2'd0;
      for (int i = 3; i >= 0; i--) begin
        if (ring_q[i*8 +: 8] == asid_i[w]) begin
          found_o[w] = 1'b1;
          ring_o[w]  = 2'(i);
        end
      end
    end
  end
endmodule

// File: rtl/tlb_attr_decode.sv
module tlb_attr_decode (
  input  logic [3:0] attr,
  output logic       can_r,
  output logic       can_w,
  output logic       can_x,
  output logic [1:0] cache
);
  always_comb begin
    can_r = 1'b0;
    can_w = 1'b0;
    can_x = 1'b0;
    cache = 2'd0;
    if (attr < 4'd12) begin
      can_r = 1'b1;
      can_x = attr[0];
      can_w = attr[1];
      cache = attr[3:2];
    end else if (attr == 4'd13) begin
      can_r = 1'b1;
      can_w = 1'b1;
      cache = 2'd3;
    end
  end

  always_comb begin
    if (attr == 4'd13) begin
      a_r7_isolate_rights : assert (can_r && can_w && !can_x && cache == 2'd3);
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_lookup_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_fetch,
  input  logic        req_store,
  input  logic [1:0]  req_priv,
  input  logic        wr_en,
  input  logic [1:0]  wr_way,
  input  logic [2:0]  wr_idx,
  input  logic [31:0] wr_vpn,
  input  logic [31:0] wr_ppn,
  input  logic [7:0]  wr_asid,
  input  logic [3:0]  wr_attr,
  input  logic        ring_wr_en,
  input  logic [31:0] ring_wr_data,
  output logic        rsp_valid,
  output logic [3:0]  rsp_cause,
  output logic [31:0] rsp_paddr,
  output logic [31:0] rsp_page_size,
  output logic [1:0]  rsp_cache
);
  entry_t           sel     [NWAYS];
  logic [7:0]       sel_asid[NWAYS];
  logic [31:0]      w_paddr [NWAYS];
  logic [31:0]      w_size  [NWAYS];
  logic [1:0]       w_ring  [NWAYS];
  logic [NWAYS-1:0] tag_hit, found, hit_w;

  tlb_entry_store u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_attr(wr_attr),
    .lk_vaddr(req_vaddr),
    .sel_o(sel), .tag_hit_o(tag_hit), .paddr_o(w_paddr), .size_o(w_size)
  );

  for (genvar w = 0; w < NWAYS; w++) begin : g_asid
    assign sel_asid[w] = sel[w].asid;
  end

  tlb_ring_map u_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ring_wr_en), .wr_data(ring_wr_data),
    .asid_i(sel_asid), .found_o(found), .ring_o(w_ring)
  );

  assign hit_w = tag_hit & found;

  logic [3:0]  hit_attr;
  logic [1:0]  hit_ring;
  logic [31:0] hit_paddr, hit_size;

  always_comb begin
    hit_attr  = '0;
    hit_ring  = '0;
    hit_paddr = '0;
    hit_size  = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (hit_w[w]) begin
        hit_attr  = hit_attr  | sel[w].attr;
        hit_ring  = hit_ring  | w_ring[w];
        hit_paddr = hit_paddr | w_paddr[w];
        hit_size  = hit_size  | w_size[w];
      end
    end
  end

  logic       dec_r, dec_w, dec_x;
  logic [1:0] dec_cache;

  tlb_attr_decode u_dec (
    .attr(hit_attr), .can_r(dec_r), .can_w(dec_w), .can_x(dec_x), .cache(dec_cache)
  );

  cause_e      cause_d;
  logic        granted;
  logic        valid_q;
  logic [3:0]  cause_q;
  logic [31:0] paddr_d, paddr_q, size_d, size_q;
  logic [1:0]  cache_d, cache_q;

  always_comb begin
    if (req_fetch)      granted = dec_x;
    else if (req_store) granted = dec_w;
    else                granted = dec_r;

    if (hit_w == '0)                   cause_d = req_fetch ? C_I_MISS  : C_D_MISS;
    else if ($countones(hit_w) > 1)    cause_d = req_fetch ? C_I_MULTI : C_D_MULTI;
    else if (hit_ring < req_priv)      cause_d = req_fetch ? C_I_PRIV  : C_D_PRIV;
    else if (!granted)                 cause_d = req_fetch ? C_F_PROHIB :
                                                 (req_store ? C_S_PROHIB : C_L_PROHIB);
    else                               cause_d = C_OK;

    paddr_d = (cause_d == C_OK) ? hit_paddr : '0;
    size_d  = (cause_d == C_OK) ? hit_size  : '0;
    cache_d = (cause_d == C_OK) ? dec_cache : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      paddr_q <= '0;
      size_q  <= '0;
      cache_q <= '0;
    end else if (req_valid) begin
      cause_q <= cause_d;
      paddr_q <= paddr_d;
      size_q  <= size_d;
      cache_q <= cache_d;
    end
  end

  assign rsp_valid     = valid_q;
  assign rsp_cause     = cause_q;
  assign rsp_paddr     = paddr_q;
  assign rsp_page_size = size_q;
  assign rsp_cache     = cache_q;

  a_r1_rsp_after_req : assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_quiet_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r4_fault_side : assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_cause == 4'd0) || (rsp_cause[3] == !$past(req_fetch)));
  a_r9_size_pow2 : assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 4'd0) |-> ($countones(rsp_page_size) == 1));
  a_r9_fault_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause != 4'd0) |-> (rsp_paddr == 32'd0 && rsp_page_size == 32'd0));
endmodule

// File: tb/tlb_lookup_tb.sv
module tlb_lookup_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_fetch = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_priv = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_way = '0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_vpn = '0;
  logic [31:0] wr_ppn = '0;
  logic [7:0]  wr_asid = '0;
  logic [3:0]  wr_attr = '0;
  logic        ring_wr_en = 1'b0;
  logic [31:0] ring_wr_data = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_cause;
  logic [31:0] rsp_paddr;
  logic [31:0] rsp_page_size;
  logic [1:0]  rsp_cache;

  always #10 clk = ~clk;

  tlb_lookup u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_fetch(req_fetch),
    .req_store(req_store), .req_priv(req_priv),
    .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_attr(wr_attr),
    .ring_wr_en(ring_wr_en), .ring_wr_data(ring_wr_data),
    .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .rsp_page_size(rsp_page_size), .rsp_cache(rsp_cache)
  );

  typedef struct {
    logic [3:0]  cause;
    logic [31:0] paddr;
    logic [31:0] size;
    logic [1:0]  cache;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [31:0] SZ4K = 32'h0000_1000;
  localparam logic [31:0] SZ1M = 32'h0010_0000;
  localparam logic [31:0] SZRG = 32'h2000_0000;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic fetch, input logic store,
                        input logic [1:0] priv, input logic [3:0] cause,
                        input logic [31:0] pa, input logic [31:0] size,
                        input logic [1:0] cache, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_fetch = fetch;
    req_store = store;
    req_priv  = priv;
    e.cause = cause; e.paddr = pa; e.size = size; e.cache = cache; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic write_entry(input logic [1:0] way, input logic [2:0] idx,
                             input logic [31:0] vpn, input logic [31:0] ppn,
                             input logic [7:0] asid, input logic [3:0] attr);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_way = way; wr_idx = idx;
    wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid; wr_attr = attr;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic write_ring(input logic [31:0] v);
    @(negedge clk);
    req_valid = 1'b0;
    ring_wr_en = 1'b1; ring_wr_data = v;
    @(negedge clk);
    ring_wr_en = 1'b0;
  endtask

  // Monitor: pops the expected item for each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected response: actual cause=%0d expected none", rsp_cause);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (rsp_cause !== e.cause || rsp_paddr !== e.paddr ||
            rsp_page_size !== e.size || rsp_cache !== e.cache) begin
          fails++;
          $display("FAIL %s: actual cause=%0d pa=%h size=%h cache=%0d expected cause=%0d pa=%h size=%h cache=%0d",
                   e.tag, rsp_cause, rsp_paddr, rsp_page_size, rsp_cache,
                   e.cause, e.paddr, e.size, e.cache);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: actual rsp_valid=%b expected 0", rsp_valid);
    end

    // R10: only the way-3 identity map is live after reset
    lookup(32'h0000_0040, 0, 0, 2'd0, 4'd0, 32'h0000_0040, SZRG, 2'd0, "R10 reset identity map unique");
    lookup(32'h4000_1234, 0, 0, 2'd0, 4'd0, 32'h4000_1234, SZRG, 2'd0, "R9 region load");
    lookup(32'h8000_0010, 1, 0, 2'd0, 4'd0, 32'h8000_0010, SZRG, 2'd0, "R7 fetch on attr 3");
    lookup(32'h4000_1234, 0, 0, 2'd1, 4'd11, 32'h0, 32'h0, 2'd0, "R6 data privilege");
    lookup(32'h4000_0000, 1, 0, 2'd3, 4'd3, 32'h0, 32'h0, 2'd0, "R6 fetch privilege");

    // R5: small-page entry overlaps region 0
    write_entry(2'd0, 3'd1, 32'h1234_5000, 32'h00AB_C000, 8'd2, 4'd1);
    lookup(32'h1234_5678, 0, 0, 2'd0, 4'd10, 32'h0, 32'h0, 2'd0, "R5 data multi-hit");
    lookup(32'h1234_5678, 1, 0, 2'd0, 4'd2, 32'h0, 32'h0, 2'd0, "R5 fetch multi-hit");

    write_entry(2'd3, 3'd0, 32'h0, 32'h0, 8'd0, 4'd0);
    lookup(32'h1234_5678, 0, 0, 2'd1, 4'd0, 32'h00AB_C678, SZ4K, 2'd0, "R9 4K translation");
    lookup(32'h1234_5678, 0, 1, 2'd1, 4'd13, 32'h0, 32'h0, 2'd0, "R8 store without write");
    lookup(32'h1234_5678, 1, 0, 2'd1, 4'd0, 32'h00AB_C678, SZ4K, 2'd0, "R7 fetch with execute");
    lookup(32'h1234_5678, 1, 0, 2'd2, 4'd3, 32'h0, 32'h0, 2'd0, "R6 ring1 below priv2");
    lookup(32'h1234_6000, 0, 0, 2'd0, 4'd9, 32'h0, 32'h0, 2'd0, "R4 data miss");
    lookup(32'h1234_6000, 1, 0, 2'd0, 4'd1, 32'h0, 32'h0, 2'd0, "R4 fetch miss");

    write_entry(2'd2, 3'd1, 32'h0050_0000, 32'h7770_0000, 8'd3, 4'd13);
    lookup(32'h0054_3210, 0, 1, 2'd2, 4'd0, 32'h7774_3210, SZ1M, 2'd3, "R7 isolate store 1M");
    lookup(32'h0054_3210, 1, 0, 2'd2, 4'd4, 32'h0, 32'h0, 2'd0, "R8 fetch on attr 13");

    write_entry(2'd1, 3'd2, 32'h0000_2000, 32'h0009_9000, 8'd4, 4'd6);
    lookup(32'h0000_2ABC, 0, 1, 2'd3, 4'd0, 32'h0009_9ABC, SZ4K, 2'd1, "R7 write-back store");
    lookup(32'h0000_2ABC, 1, 0, 2'd3, 4'd4, 32'h0, 32'h0, 2'd0, "R8 fetch without execute");

    write_entry(2'd1, 3'd3, 32'h0000_3000, 32'h0000_1000, 8'd4, 4'd14);
    lookup(32'h0000_3004, 0, 0, 2'd0, 4'd12, 32'h0, 32'h0, 2'd0, "R8 load on attr 14");

    write_entry(2'd0, 3'd0, 32'h0000_0000, 32'h0055_5000, 8'd9, 4'd3);
    lookup(32'h0000_0100, 0, 0, 2'd3, 4'd9, 32'h0, 32'h0, 2'd0, "R3 unknown tag misses");
    write_ring(32'h0903_0201);
    lookup(32'h0000_0100, 0, 0, 2'd3, 4'd0, 32'h0055_5100, SZ4K, 2'd0, "R3 tag now ring3");
    write_ring(32'h0202_0202);
    lookup(32'h1234_5678, 0, 0, 2'd1, 4'd11, 32'h0, 32'h0, 2'd0, "R3 lowest byte wins");

    write_entry(2'd0, 3'd2, 32'h0000_6FFF, 32'h0012_3FFF, 8'd2, 4'd3);
    lookup(32'h0000_6004, 0, 0, 2'd0, 4'd0, 32'h0012_3004, SZ4K, 2'd0, "R11 write masks low bits");
    lookup(32'h0000_6004, 1, 0, 2'd0, 4'd0, 32'h0012_3004, SZ4K, 2'd0, "R2 way0 slot2 fetch");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 missing responses: actual pending=%0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule